// File: doc/BRIEF.md
# Stereo Serial Audio Receiver with Zero-Input Flag

This block takes a three-wire serial stereo audio stream (a bit clock, a channel-select framing clock and one data line) and turns it into parallel 16-bit two's-complement samples, one word per channel. The three serial lines are asynchronous to the system clock. They are brought into the system clock domain through a short synchronizer chain, and their edges are found there. Once a right-channel word has finished, the left and right words of that frame are presented together on a parallel output with a single-cycle valid strobe.

Beside the sample path, a silence detector counts consecutive frames in which both channel words are zero. After a configurable number of such frames (8192 by default) it raises a flag. The flag drops again without any outside action as soon as a frame with non-zero data arrives. A downstream stage can use this flag to mute or power down.

Top module: `stereo_rx`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `pair_valid_o`, `zero_flag_o`, `left_o` and `right_o` are all 0.
- R2: Each data bit is taken on a rising edge of the bit clock, most significant bit first. A full 16-bit word reaches the output unchanged as a two's-complement value.
- R3: Bits received while the framing clock is high form the left word and appear on `left_o`. Bits received while it is low form the right word and appear on `right_o`.
- R4: Each low-to-high transition of the framing clock that ends a right word following a left word produces exactly one single-cycle `pair_valid_o` pulse. The left word is held internally until that pulse, and no pulse happens otherwise.
- R5: A word with fewer than 16 bit-clock edges is left-aligned. The received bits fill the upper positions and the remaining lower bits are 0.
- R6: A word with more than 16 bit-clock edges keeps its first 16 bits, and the extra bits are dropped.
- R7: `zero_flag_o` goes to 1 on the cycle after the valid pulse of the ZERO_FRAMES-th consecutive pair in which both words are 0. It stays 1 through further all-zero pairs.
- R8: `zero_flag_o` returns to 0 on the cycle after the valid pulse of any pair that has a non-zero word. The zero-frame count restarts from 0 at that point.
- R9: Bits received before the first framing-clock transition after reset are discarded. A right word that has no preceding left word produces no pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit clock rate |
| rst | input | 1 | Synchronous active-high reset |
| bck_in | input | 1 | Serial bit clock, asynchronous |
| lrck_in | input | 1 | Framing clock: 1 selects left, 0 selects right |
| sdata_in | input | 1 | Serial data, MSB first |
| pair_valid_o | output | 1 | One-cycle strobe when a left/right pair is presented |
| left_o | output | 16 | Left sample, two's complement |
| right_o | output | 16 | Right sample, two's complement |
| zero_flag_o | output | 1 | High after a long run of all-zero frames |

## Verification
The hardest states to reach are at the framing boundaries. These are a right word that arrives before any left word, and words that are cut short or run past sixteen bits. A bench that only sends well-formed frames never produces any of them. The stimulus drives the serial lines directly and sets a separate bit count for every word, so short, long and orphan words are placed exactly where they are wanted. The zero flag is taken through set, hold, clear and a run one frame short of the threshold by using a small frame threshold.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;

    localparam int SR_WORD_W  = 16;
    localparam int SR_BCNT_W  = $clog2(SR_WORD_W + 1);
    localparam int SR_IDX_W   = $clog2(SR_WORD_W);

    typedef logic signed [SR_WORD_W-1:0] sr_sample_t;

    typedef struct packed {
        sr_sample_t left;
        sr_sample_t right;
    } sr_pair_t;

    // serial lines after synchronization, with their edge events
    typedef struct packed {
        logic bck_rise;
        logic lr_edge;
        logic lr_lvl;
        logic din;
    } sr_line_t;

    function automatic logic sr_pair_is_zero(input sr_pair_t p);
        return (p.left == '0) && (p.right == '0);
    endfunction

endpackage

// File: rtl/stereo_rx_sync.sv
module stereo_rx_sync
    import stereo_rx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bck_in,
    input  logic     lrck_in,
    input  logic     sdata_in,
    output sr_line_t line_o
);

    localparam int NSIG = 3;

    // chain[0] is the first capture stage; one extra stage holds the previous level
    logic [NSIG-1:0] chain [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= {sdata_in, lrck_in, bck_in};
        end
    end

    genvar g;
    generate
        for (g = 1; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    logic [NSIG-1:0] cur, prv;
    assign cur = chain[STAGES-1];
    assign prv = chain[STAGES];

    always_comb begin
        line_o.bck_rise = cur[0] & ~prv[0];
        line_o.lr_edge  = cur[1] ^ prv[1];
        line_o.lr_lvl   = cur[1];
        line_o.din      = cur[2];
    end

endmodule

// File: rtl/stereo_rx_assemble.sv
module stereo_rx_assemble
    import stereo_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sr_line_t line_i,
    output sr_pair_t pair_o,
    output logic     pair_valid_o
);

    sr_sample_t           word_q;
    sr_sample_t           left_hold_q;
    logic [SR_BCNT_W-1:0] bcnt_q;
    logic                 armed_q;
    logic                 have_left_q;

    logic [SR_IDX_W-1:0]  bit_idx;
    assign bit_idx = SR_IDX_W'(SR_WORD_W - 1) - bcnt_q[SR_IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q       <= '0;
            left_hold_q  <= '0;
            bcnt_q       <= '0;
            armed_q      <= 1'b0;
            have_left_q  <= 1'b0;
            pair_o       <= '0;
            pair_valid_o <= 1'b0;
        end else begin
            pair_valid_o <= 1'b0;
            if (line_i.lr_edge) begin
                // left word finished: park it until the right word closes
                if (!line_i.lr_lvl && armed_q) begin
                    left_hold_q <= word_q;
                    have_left_q <= 1'b1;
                end
                // right word finished behind a left word: publish the pair
                if (line_i.lr_lvl && have_left_q) begin
                    pair_o.left  <= left_hold_q;
                    pair_o.right <= word_q;
                    pair_valid_o <= 1'b1;
                    have_left_q  <= 1'b0;
                end
                armed_q <= 1'b1;
                word_q  <= '0;
                bcnt_q  <= '0;
            end else if (line_i.bck_rise && armed_q &&
                         (bcnt_q < SR_BCNT_W'(SR_WORD_W))) begin
                word_q[bit_idx] <= line_i.din;
                bcnt_q          <= bcnt_q + 1'b1;
            end
        end
    end

    // R4: strobe lasts one cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        pair_valid_o |=> !pair_valid_o);

    // R4: strobe only follows a detected rise of the framing clock
    p_valid_src_r4: assert property (@(posedge clk) disable iff (rst)
        pair_valid_o |-> $past(line_i.lr_edge && line_i.lr_lvl));

endmodule

// File: rtl/stereo_rx_zero.sv
module stereo_rx_zero
    import stereo_rx_pkg::*;
#(
    parameter int ZERO_FRAMES = 8192
) (
    input  logic     clk,
    input  logic     rst,
    input  sr_pair_t pair_i,
    input  logic     pair_valid_i,
    output logic     zero_flag_o
);

    localparam int ZC_W = $clog2(ZERO_FRAMES + 1);
    localparam logic [ZC_W-1:0] ZC_MAX  = ZC_W'(ZERO_FRAMES);
    localparam logic [ZC_W-1:0] ZC_LAST = ZC_W'(ZERO_FRAMES - 1);

    logic [ZC_W-1:0] zcnt_q;
    logic            quiet;

    assign quiet = sr_pair_is_zero(pair_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            zcnt_q      <= '0;
            zero_flag_o <= 1'b0;
        end else if (pair_valid_i) begin
            if (quiet) begin
                if (zcnt_q != ZC_MAX) zcnt_q <= zcnt_q + 1'b1;
                if (zcnt_q >= ZC_LAST) zero_flag_o <= 1'b1;
            end else begin
                zcnt_q      <= '0;
                zero_flag_o <= 1'b0;
            end
        end
    end

    // R7: the flag is raised only by a completed pair
    p_flag_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(zero_flag_o) |-> $past(pair_valid_i && quiet));

    // R8: the flag is dropped only by a completed non-zero pair
    p_flag_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(zero_flag_o) |-> $past(pair_valid_i && !quiet));

endmodule

// File: rtl/stereo_rx.sv
module stereo_rx
    import stereo_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ZERO_FRAMES = 8192
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bck_in,
    input  logic                 lrck_in,
    input  logic                 sdata_in,
    output logic                 pair_valid_o,
    output logic [SR_WORD_W-1:0] left_o,
    output logic [SR_WORD_W-1:0] right_o,
    output logic                 zero_flag_o
);

    sr_line_t line;
    sr_pair_t pair;
    logic     pair_valid;

    stereo_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .bck_in   (bck_in),
        .lrck_in  (lrck_in),
        .sdata_in (sdata_in),
        .line_o   (line)
    );

    stereo_rx_assemble u_asm (
        .clk          (clk),
        .rst          (rst),
        .line_i       (line),
        .pair_o       (pair),
        .pair_valid_o (pair_valid)
    );

    stereo_rx_zero #(.ZERO_FRAMES(ZERO_FRAMES)) u_zero (
        .clk          (clk),
        .rst          (rst),
        .pair_i       (pair),
        .pair_valid_i (pair_valid),
        .zero_flag_o  (zero_flag_o)
    );

    assign pair_valid_o = pair_valid;
    assign left_o       = pair.left;
    assign right_o      = pair.right;

endmodule

// File: tb/stereo_rx_tb_top.sv
`timescale 1ns/1ps
module stereo_rx_tb_top;

    localparam int LIM  = 4;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bck = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic        vld;
    logic [15:0] lo, ro;
    logic        zf;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    stereo_rx #(.SYNC_STAGES(2), .ZERO_FRAMES(LIM)) dut_i (
        .clk(clk), .rst(rst), .bck_in(bck), .lrck_in(lrck), .sdata_in(sdata),
        .pair_valid_o(vld), .left_o(lo), .right_o(ro), .zero_flag_o(zf)
    );

    // behavioural reference state
    logic [31:0] expq[$];
    bit          m_armed = 0, m_have = 0, m_lr = 0, prev_vld = 0;
    logic [15:0] m_left = '0, m_word = '0;
    int          m_zc = 0;
    bit          m_flag = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // send one word: n bits taken MSB-first from bits[31:...]
    task automatic send_word(input bit lvl, input logic [31:0] bits, input int n);
        logic [15:0] w;
        w = bits[31:16];
        if (n < 16) w = w & ~(16'hFFFF >> n);
        if (lvl != m_lr) begin
            if (!lvl && m_armed) begin m_left = m_word; m_have = 1; end
            if (lvl && m_have) begin expq.push_back({m_left, m_word}); m_have = 0; end
            m_armed = 1;
        end
        m_lr = lvl;
        m_word = w;
        bck = 1'b0; lrck = lvl;
        tick(HALF);
        for (int i = 0; i < n; i++) begin
            bck = 1'b0; sdata = bits[31-i];
            tick(HALF);
            bck = 1'b1;
            tick(HALF);
        end
    endtask

    task automatic send_pair(input logic [15:0] l, input logic [15:0] r);
        send_word(1'b1, {l, 16'h0}, 16);
        send_word(1'b0, {r, 16'h0}, 16);
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            check(zf == m_flag, "R7/R8", "zero flag", 32'(zf), 32'(m_flag));
            if (vld) begin
                check(!prev_vld, "R4", "valid longer than one cycle", 1, 0);
                if (expq.size() == 0) begin
                    check(0, "R4/R9", "unexpected pair", {lo, ro}, 0);
                end else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    check(lo == e[31:16], "R2/R3", "left word", 32'(lo), 32'(e[31:16]));
                    check(ro == e[15:0],  "R2/R3", "right word", 32'(ro), 32'(e[15:0]));
                    if (e == 0) begin
                        m_zc++;
                        if (m_zc >= LIM) m_flag = 1;
                    end else begin
                        m_zc = 0;
                        m_flag = 0;
                    end
                end
            end
            prev_vld = vld;
        end
    end

    initial begin
        tick(6);
        check(vld == 0 && zf == 0 && lo == 0 && ro == 0, "R1", "outputs in reset",
              {lo, ro} | 32'(vld) | 32'(zf), 0);
        rst = 1'b0;
        tick(1);
        check(vld == 0 && zf == 0 && lo == 0 && ro == 0, "R1", "outputs after reset",
              {lo, ro}, 0);

        // R9: right bits with no framing edge yet, then a left/right with orphan right first
        send_word(1'b0, 32'hDEAD_0000, 16);
        send_word(1'b1, 32'h1111_0000, 16);
        send_word(1'b0, 32'h2222_0000, 16);
        // R2, R3: sign extremes and mixed patterns
        send_pair(16'h8000, 16'h7FFF);
        send_pair(16'hFFFF, 16'h0001);
        send_pair(16'h1234, 16'hA5C3);
        // R5: short words
        send_word(1'b1, 32'hFFFF_FFFF, 10);
        send_word(1'b0, 32'hA000_0000, 3);
        // R6: long words
        send_word(1'b1, 32'hBEEF_C000, 20);
        send_word(1'b0, 32'h0F0F_FFFF, 24);
        // R7: run of zero pairs sets the flag and holds it
        for (int k = 0; k < LIM + 1; k++) send_pair(16'h0, 16'h0);
        // R8: non-zero right clears it
        send_pair(16'h0, 16'h0001);
        // one short of the threshold, then a break, then a full run
        for (int k = 0; k < LIM - 1; k++) send_pair(16'h0, 16'h0);
        send_pair(16'h0040, 16'h0);
        for (int k = 0; k < LIM; k++) send_pair(16'h0, 16'h0);
        // flush the last right word
        send_word(1'b1, 32'h5555_0000, 16);
        tick(20);
        check(zf == 1, "R7", "flag set after full zero run", 32'(zf), 1);
        check(expq.size() == 0, "R4", "pairs outstanding", 32'(expq.size()), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule